// File: doc/BRIEF.md
# Calibrated Second-Tick Prescaler

This block turns a slow oscillator clock enable (nominally 32.768 kHz, seen as a one-cycle pulse in the system clock domain) into a one-second strobe for a real-time-clock time core. The length of each second comes from a calibration word. The word holds an integer tick count, plus an optional fractional correction in sixteenths of a tick that is spread over a repeating sixteen-second cycle. Software writes the word through a write port. The read port always shows the word that is currently governing the count, which may differ from the word just written.

A written word waits and takes over only at the next second boundary, so a second that is already running is never cut short. While the word in use is zero, the block treats itself as uncalibrated and divides by a fixed default of 32768 ticks. Software can detect this by reading back zero and then load a proper value.

The controller has three states. ST_DEFAULT counts with the built-in terminal value. ST_COUNT counts up to the programmed integer field. ST_EXTRA spends one extra oscillator tick inside the current second. The named transitions are:
- default-wrap: ST_DEFAULT at terminal with a tick.
- count-wrap: ST_COUNT at terminal, no extra due.
- count-to-extra: ST_COUNT at terminal, extra due.
- extra-wrap: ST_EXTRA with a tick.

Every wrap is a second boundary. At each boundary the next state is chosen as ST_DEFAULT if the word about to be in use is zero, and ST_COUNT otherwise.

Top module: `sec_prescaler`

## Requirements
- R1: After reset the read port shows 0, the tick count is 0 and the seconds strobe is low.
- R2: While the word in use is zero, one strobe is produced every 32768 oscillator ticks.
- R3: With a nonzero word whose bit 20 is clear, or whose 4-bit field in bits 19:16 is zero, each second lasts (bits 15:0) + 1 ticks. Bits 19:16 have no effect while bit 20 is clear.
- R4: A 4-bit phase counter counts strobes since reset, modulo 16. With bit 20 set and field F in bits 19:16, a second that starts while the phase is below F lasts one extra tick.
- R5: A write takes effect only at the next strobe, and the read port changes only in a cycle where the strobe is high. If several writes land in one second, the last one wins.
- R6: The tick count and the strobe change only after a cycle in which the oscillator enable was high. The strobe is high for one system clock cycle per second.
- R7: The tick count equals the number of ticks since the last strobe. It is 0 in the strobe cycle, and it holds its terminal value during the extra tick.
- R8: The tick count never exceeds the terminal value of the word in use (32767 when that word is zero).
- R9: Writing zero after a calibration returns the block to the 32768-tick default from the next boundary on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle enable per oscillator tick |
| cal_wr_en | input | 1 | Write strobe for the calibration word |
| cal_wr_data | input | 21 | Calibration word to stage (bit 20 enable, 19:16 fraction, 15:0 integer) |
| cal_rd_data | output | 21 | Calibration word currently in use |
| tick_count | output | 16 | Ticks counted in the running second |
| sec_strobe | output | 1 | One-cycle pulse at each second boundary |

## Verification
The bench models the phase counter and the staged word on its own, and measures the length of every second in ticks. This catches two kinds of fault: fractional extras landing in the wrong seconds of the sixteen-second cycle, and a fraction being applied while its enable bit is clear. Writes are placed in the middle of a second, and also back to back. This exposes a design that switches words early, showing a new read value before the boundary or shortening the current second, and one that keeps the first of two writes instead of the last. Integer count zero, a full fraction of 15, and a return to zero are all driven. These expose an off-by-one terminal value, an extra tick that never ends, and a design that keeps the old divisor after being decalibrated. The oscillator enable has gaps, so a counter that advances on the system clock rather than on ticks shows up at once.

// File: rtl/sec_prescaler_pkg.sv
package sec_prescaler_pkg;

    typedef enum logic [1:0] {
        ST_DEFAULT = 2'd0,
        ST_COUNT   = 2'd1,
        ST_EXTRA   = 2'd2
    } presc_state_e;

endpackage

// File: rtl/sec_cal_store.sv
module sec_cal_store #(
    parameter int CAL_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CAL_W-1:0] wr_data,
    input  logic             apply,
    output logic [CAL_W-1:0] active_word,
    output logic [CAL_W-1:0] next_word
);

    logic [CAL_W-1:0] staged_word;
    logic             staged_vld;

    // Word that will govern the second starting after a boundary
    assign next_word = staged_vld ? staged_word : active_word;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_word <= '0;
            staged_word <= '0;
            staged_vld  <= 1'b0;
        end else begin
            if (apply) begin
                active_word <= next_word;
                staged_vld  <= 1'b0;
            end
            // A write in a boundary cycle waits for the following boundary
            if (wr_en) begin
                staged_word <= wr_data;
                staged_vld  <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sec_frac_phase.sv
module sec_frac_phase #(
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              frac_en,
    input  logic [FRAC_W-1:0] frac_val,
    output logic              extra_due
);

    logic [FRAC_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (advance) begin
            phase <= phase + 1'b1;
        end
    end

    assign extra_due = frac_en && (phase < frac_val);

endmodule

// File: rtl/sec_prescaler.sv
module sec_prescaler
    import sec_prescaler_pkg::*;
#(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      osc_tick,
    input  logic                      cal_wr_en,
    input  logic [INT_W+FRAC_W:0]     cal_wr_data,
    output logic [INT_W+FRAC_W:0]     cal_rd_data,
    output logic [INT_W-1:0]          tick_count,
    output logic                      sec_strobe
);

    localparam int CAL_W  = INT_W + FRAC_W + 1;
    localparam int EN_BIT = INT_W + FRAC_W;
    localparam logic [INT_W-1:0] DEF_TERM = {1'b0, {(INT_W-1){1'b1}}};

    presc_state_e     state, state_nx;
    logic [CAL_W-1:0] active_word, next_word;
    logic [INT_W-1:0] term_int;
    logic             wrap, advance, extra_due;

    sec_cal_store #(.CAL_W(CAL_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cal_wr_en),
        .wr_data     (cal_wr_data),
        .apply       (wrap),
        .active_word (active_word),
        .next_word   (next_word)
    );

    generate
        if (FRAC_W > 0) begin : g_frac
            sec_frac_phase #(.FRAC_W(FRAC_W)) u_phase (
                .clk       (clk),
                .rst_n     (rst_n),
                .advance   (wrap),
                .frac_en   (active_word[EN_BIT]),
                .frac_val  (active_word[EN_BIT-1:INT_W]),
                .extra_due (extra_due)
            );
        end else begin : g_nofrac
            assign extra_due = 1'b0;
        end
    endgenerate

    assign term_int    = active_word[INT_W-1:0];
    assign cal_rd_data = active_word;

    // Next-state and boundary decode
    always_comb begin
        state_nx = state;
        wrap     = 1'b0;
        advance  = 1'b0;
        if (osc_tick) begin
            unique case (state)
                ST_DEFAULT: begin
                    if (tick_count == DEF_TERM) wrap = 1'b1;   // default-wrap
                    else                        advance = 1'b1;
                end
                ST_COUNT: begin
                    if (tick_count != term_int) advance = 1'b1;
                    else if (extra_due)         state_nx = ST_EXTRA; // count-to-extra
                    else                        wrap = 1'b1;   // count-wrap
                end
                ST_EXTRA: wrap = 1'b1;                         // extra-wrap
                default:  wrap = 1'b1;
            endcase
        end
        if (wrap) begin
            state_nx = (next_word == '0) ? ST_DEFAULT : ST_COUNT;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_DEFAULT;
        else        state <= state_nx;
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_count <= '0;
            sec_strobe <= 1'b0;
        end else begin
            sec_strobe <= wrap;
            if (wrap)         tick_count <= '0;
            else if (advance) tick_count <= tick_count + 1'b1;
        end
    end

endmodule

// File: rtl/sec_prescaler_chk.sv
module sec_prescaler_chk #(
    parameter int INT_W = 16,
    parameter int CAL_W = 21
) (
    input logic             clk,
    input logic             rst_n,
    input logic             osc_tick,
    input logic             sec_strobe,
    input logic [INT_W-1:0] tick_count,
    input logic [CAL_W-1:0] cal_rd_data
);

    localparam logic [INT_W-1:0] DEF_TERM = {1'b0, {(INT_W-1){1'b1}}};

    AST_STROBE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        sec_strobe |-> $past(osc_tick)); // R6

    AST_QUIET_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_tick |=> (!sec_strobe && $stable(tick_count))); // R6

    AST_STROBE_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        sec_strobe |-> (tick_count == '0)); // R7

    AST_CAL_CHANGES_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_strobe |-> $stable(cal_rd_data)); // R5

    AST_DEFAULT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_rd_data == '0) |-> (tick_count <= DEF_TERM)); // R2

    AST_CAL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_rd_data != '0) |-> (tick_count <= cal_rd_data[INT_W-1:0])); // R8

endmodule

bind sec_prescaler sec_prescaler_chk #(.INT_W(INT_W), .CAL_W(CAL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .osc_tick    (osc_tick),
    .sec_strobe  (sec_strobe),
    .tick_count  (tick_count),
    .cal_rd_data (cal_rd_data)
);

// File: tb/tb_sec_prescaler.sv
module tb_sec_prescaler;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        osc_tick;
    logic        cal_wr_en;
    logic [20:0] cal_wr_data;
    logic [20:0] cal_rd_data;
    logic [15:0] tick_count;
    logic        sec_strobe;

    always #4 clk = ~clk;   // 125 MHz

    sec_prescaler dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .osc_tick    (osc_tick),
        .cal_wr_en   (cal_wr_en),
        .cal_wr_data (cal_wr_data),
        .cal_rd_data (cal_rd_data),
        .tick_count  (tick_count),
        .sec_strobe  (sec_strobe)
    );

    int          checks = 0;
    int          fails  = 0;
    int          n      = 0;     // ticks consumed in the running second
    int          fs     = 0;     // model of the 16-second phase
    int          secs   = 0;
    int          gc     = 0;
    logic [20:0] act    = '0;    // model: word in use
    logic [20:0] pend   = '0;
    bit          pv     = 0;
    bit          zero_back = 0;
    bit          tc_bad = 0;
    bit          rd_bad = 0;

    task automatic check(input bit ok, input string req, input longint a, input longint e);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, a, e);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic cyc(input bit wr, input logic [20:0] d);
        longint exp;
        osc_tick    = (gc % 4) != 3;
        cal_wr_en   = wr;
        cal_wr_data = d;
        @(posedge clk);
        #1;
        gc++;
        if (osc_tick) n++;
        if (sec_strobe) begin
            if (act == 0) exp = 32768;
            else exp = longint'(act[15:0]) + 1 + ((act[20] && fs < act[19:16]) ? 1 : 0);
            check(n == exp,
                  (act == 0) ? (zero_back ? "R9" : "R2")
                             : ((act[20] && act[19:16] != 0) ? "R4" : "R3"), n, exp);
            check(osc_tick, "R6", osc_tick, 1);
            check(!tc_bad && tick_count == 0, "R7", tick_count, 0);
            check(!rd_bad, "R5", cal_rd_data, act);
            tc_bad = 0;
            rd_bad = 0;
            n  = 0;
            fs = (fs + 1) % 16;
            if (pv) begin
                act = pend;
                pv  = 0;
            end
            secs++;
        end else begin
            if (act == 0) exp = n;
            else exp = (n > act[15:0]) ? longint'(act[15:0]) : n;
            if (tick_count != exp) tc_bad = 1;
        end
        if (cal_rd_data != act) rd_bad = 1;
        if (wr) begin
            pend = d;
            pv   = 1;
        end
        cal_wr_en = 1'b0;
    endtask

    task automatic run_secs(input int k);
        int target = secs + k;
        while (secs < target) cyc(1'b0, '0);
    endtask

    task automatic run_cycles(input int m);
        for (int i = 0; i < m; i++) cyc(1'b0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R2 watchdog: actual %0d cycles expected completion", 200000);
        summary();
        $finish;
    end

    initial begin
        rst_n       = 1'b0;
        osc_tick    = 1'b0;
        cal_wr_en   = 1'b0;
        cal_wr_data = '0;
        repeat (5) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: reset state
        check(cal_rd_data == 0, "R1", cal_rd_data, 0);
        check(tick_count == 0, "R1", tick_count, 0);
        check(sec_strobe == 0, "R1", sec_strobe, 0);

        // R5: write while uncalibrated is deferred to the first boundary
        cyc(1'b1, 21'h00002);
        check(cal_rd_data == 0, "R5", cal_rd_data, 0);
        run_secs(1);                       // R2 default second
        check(cal_rd_data == 21'h00002, "R5", cal_rd_data, 2);
        run_secs(4);                       // R3 period 3

        // R4: fraction 5 over integer 3, written mid-second
        run_cycles(2);
        cyc(1'b1, (21'd1 << 20) | (21'd5 << 16) | 21'd3);
        check(cal_rd_data == 21'h00002, "R5", cal_rd_data, 2);
        run_secs(34);

        // R3: fraction field ignored while its enable is clear
        cyc(1'b1, (21'd7 << 16) | 21'd1);
        run_secs(18);

        // R4: full fraction over integer zero
        cyc(1'b1, (21'd1 << 20) | (21'd15 << 16));
        run_secs(20);

        // R3: enabled with a zero fraction
        cyc(1'b1, (21'd1 << 20) | 21'd4);
        run_secs(5);

        // R5: last of two writes in a second wins
        run_cycles(1);
        cyc(1'b1, 21'd9);
        cyc(1'b1, 21'd6);
        run_secs(2);
        check(cal_rd_data == 21'd6, "R5", cal_rd_data, 6);

        // R9: back to the default divide
        zero_back = 1;
        cyc(1'b1, 21'd0);
        run_secs(2);
        check(cal_rd_data == 0, "R9", cal_rd_data, 0);

        summary();
        $finish;
    end

endmodule